// File: doc/BRIEF.md
# Open-Page DRAM Request Scheduler

This block sits between a last-level cache and one DDR2-style memory channel. Read and write requests, each with a 32-bit physical address and a tag, enter a small request buffer through a ready/valid handshake. The scheduler picks one request at a time. It prefers reads over writes and row hits over misses, and takes the oldest entry when the two are equal. A write that has been passed over for too long is promoted above every read.

For the chosen request the block issues only the DRAM commands the bank's current state needs. A hit gets a column access alone. A bank with no open row gets an activate and then the column access. A bank holding a different row gets a precharge, an activate and the column access. Per-bank down-counters hold each command back until its bank's minimum gap has elapsed.

A request completes a fixed CAS latency after its column command. The completion port returns the tag and the read/write flag. In open-page mode the row stays open afterwards. In closed-page mode the block precharges it before it serves the next request.

Top module: `dram_sched`

## Requirements
- R1: The address splits into row [31:14], channel [13], bank [12:10] and column [9:0]. While a request is served, `mem_row`, `mem_chan`, `mem_bank` and `mem_col` carry those fields, and `mem_write` is high with a column command of a write.
- R2: A request whose bank already holds its row gets only a column command (`mem_cmd` = 3), with no precharge (1) or activate (2). A column command only ever targets the bank's open row.
- R3: A request to a bank with no open row gets an activate and then a column command. A request to a bank holding another row gets a precharge, an activate and a column command, in that order.
- R4: `done_valid` pulses exactly T_CL (default 4) cycles after the column command of the request, with that request's tag and write flag. Only one request is in service at a time.
- R5: The next request served is a read before any write, then a row hit before a miss, then the oldest entry.
- R6: A write that has waited more than `cfg_starve_lim` cycles in the buffer is served before all reads.
- R7: With `cfg_closed_page` high, the row is precharged after each access, before the next request is picked, so the next access to that bank needs an activate.
- R8: Within a bank, activate to column is at least T_RCD (4) cycles, activate to precharge at least T_RAS (14), and precharge to activate at least T_PA (18).
- R9: The buffer holds DEPTH (default 4) requests. When it is full, `req_ready` is low and a pending request waits without being lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_closed_page | input | 1 | 1: precharge after every access |
| cfg_starve_lim | input | WAIT_W | Write wait limit in cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Buffer has room |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 32 | Physical address |
| req_tag | input | TAG_W | Request tag |
| mem_cmd | output | 2 | 0 none, 1 precharge, 2 activate, 3 column |
| mem_bank | output | BANK_W | Bank of current request |
| mem_row | output | ROW_W | Row of current request |
| mem_col | output | COL_W | Column of current request |
| mem_chan | output | CH_W | Channel field of current request |
| mem_write | output | 1 | Column command is a write |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | TAG_W | Tag of completed request |
| done_write | output | 1 | Completed request was a write |

## Verification
The bench fills the buffer while one long request is in service and then checks the order of completions. Three cases are covered: a younger read hit overtaking a write hit and a read miss, a hit overtaking an older miss among reads, and a starved write beating a read. A design with wrong priority bits shows up there as swapped tags. A command monitor keeps its own model of open rows and counts the commands each request receives. It catches a missing or redundant precharge or activate, a column command to a closed or wrong row, and a gap shorter than the bank timings, in particular the 18-cycle precharge-to-activate gap after a closed-page auto-precharge. It also checks completion latency and decoded fields against each scoreboard entry, and holds a request at a full buffer to confirm nothing is lost.

// File: rtl/dsch_pkg.sv
package dsch_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_ACT = 2'd2,
    CMD_CAS = 2'd3
  } dcmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_CAS, ST_WAIT, ST_APRE
  } dstate_e;
endpackage

// File: rtl/dsch_buf.sv
// Compacting request buffer: entry 0 is always the oldest.
module dsch_buf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8,
  parameter int WAIT_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic                              in_write,
  input  logic [ADDR_W-1:0]                 in_addr,
  input  logic [TAG_W-1:0]                  in_tag,
  input  logic                              pop,
  input  logic [IDX_W-1:0]                  pop_idx,
  output logic [DEPTH-1:0]                  ent_vld,
  output logic [DEPTH-1:0]                  ent_write,
  output logic [DEPTH-1:0][ADDR_W-1:0]      ent_addr,
  output logic [DEPTH-1:0][TAG_W-1:0]       ent_tag,
  output logic [DEPTH-1:0][WAIT_W-1:0]      ent_wait
);
  logic [DEPTH-1:0]             vld_q, vld_n, wr_q, wr_n;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q, addr_n;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q, tag_n;
  logic [DEPTH-1:0][WAIT_W-1:0] wt_q, wt_n, wt_inc;
  logic                         found;

  assign in_ready = ~vld_q[DEPTH-1];

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      wt_inc[i] = (vld_q[i] && (wt_q[i] != '1)) ? wt_q[i] + 1'b1 : wt_q[i];
    vld_n  = vld_q;
    wr_n   = wr_q;
    addr_n = addr_q;
    tag_n  = tag_q;
    wt_n   = wt_inc;
    found  = 1'b0;
    if (pop) begin
      for (int i = 0; i < DEPTH-1; i++) begin
        if (i >= int'(pop_idx)) begin
          vld_n[i]  = vld_q[i+1];
          wr_n[i]   = wr_q[i+1];
          addr_n[i] = addr_q[i+1];
          tag_n[i]  = tag_q[i+1];
          wt_n[i]   = wt_inc[i+1];
        end
      end
      vld_n[DEPTH-1] = 1'b0;
    end
    if (in_valid && in_ready) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!found && !vld_n[i]) begin
          found     = 1'b1;
          vld_n[i]  = 1'b1;
          wr_n[i]   = in_write;
          addr_n[i] = in_addr;
          tag_n[i]  = in_tag;
          wt_n[i]   = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    wr_q   <= wr_n;
    addr_q <= addr_n;
    tag_q  <= tag_n;
    wt_q   <= wt_n;
  end

  assign ent_vld   = vld_q;
  assign ent_write = wr_q;
  assign ent_addr  = addr_q;
  assign ent_tag   = tag_q;
  assign ent_wait  = wt_q;

  assert_pop_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> vld_q[pop_idx]);

  assert_push_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !pop) |=> ($countones(vld_q) == $past($countones(vld_q)) + 1));
endmodule

// File: rtl/dsch_pick.sv
// Chooses the next entry by {starved write, read, row hit}, oldest on ties.
module dsch_pick #(
  parameter int DEPTH  = 4,
  parameter int WAIT_W = 8,
  parameter int NBANK  = 8,
  parameter int ROW_W  = 18,
  localparam int BANK_W = $clog2(NBANK),
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]              ent_vld,
  input  logic [DEPTH-1:0]              ent_write,
  input  logic [DEPTH-1:0][BANK_W-1:0]  ent_bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]   ent_row,
  input  logic [DEPTH-1:0][WAIT_W-1:0]  ent_wait,
  input  logic [NBANK-1:0]              bank_open,
  input  logic [NBANK-1:0][ROW_W-1:0]   bank_row,
  input  logic [WAIT_W-1:0]             starve_lim,
  output logic                          sel_any,
  output logic [IDX_W-1:0]              sel_idx
);
  logic [2:0] score, best;
  logic       hit;

  always_comb begin
    sel_any = |ent_vld;
    sel_idx = '0;
    best    = '0;
    score   = '0;
    hit     = 1'b0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (ent_vld[i]) begin
        hit   = bank_open[ent_bank[i]] && (bank_row[ent_bank[i]] == ent_row[i]);
        score = {ent_write[i] && (ent_wait[i] > starve_lim), ~ent_write[i], hit};
        if (score >= best) begin
          best    = score;
          sel_idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/dsch_bank.sv
// Per-bank open-row state and minimum-gap down-counters.
module dsch_bank #(
  parameter int ROW_W = 18,
  parameter int CNT_W = 6,
  parameter int T_RCD = 4,
  parameter int T_RAS = 14,
  parameter int T_PA  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_pre,
  input  logic             do_act,
  input  logic             do_cas,
  input  logic [ROW_W-1:0] act_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             may_pre,
  output logic             may_act,
  output logic             may_cas
);
  logic             open_q, open_n;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] ras_q, ras_n, gap_q, gap_n;

  always_comb begin
    open_n = open_q;
    if (do_act) open_n = 1'b1;
    if (do_pre) open_n = 1'b0;
    if (do_act)           ras_n = CNT_W'(T_RAS-1);
    else if (ras_q != '0) ras_n = ras_q - 1'b1;
    else                  ras_n = ras_q;
    if (do_act)           gap_n = CNT_W'(T_RCD-1);
    else if (do_pre)      gap_n = CNT_W'(T_PA-1);
    else if (gap_q != '0) gap_n = gap_q - 1'b1;
    else                  gap_n = gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ras_q  <= '0;
      gap_q  <= '0;
    end else begin
      open_q <= open_n;
      ras_q  <= ras_n;
      gap_q  <= gap_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_act) row_q <= act_row;
  end

  assign is_open  = open_q;
  assign open_row = row_q;
  assign may_pre  = open_q && (ras_q == '0);
  assign may_act  = !open_q && (gap_q == '0);
  assign may_cas  = open_q && (gap_q == '0);

  assert_act_shut_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |-> (!open_q && gap_q == '0));

  assert_cas_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_cas |-> (open_q && gap_q == '0));

  assert_pre_ras_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_pre |-> (open_q && ras_q == '0));

  assert_one_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({do_pre, do_act, do_cas}) <= 1);
endmodule

// File: rtl/dram_sched.sv
module dram_sched
  import dsch_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 8,
  parameter int WAIT_W = 8,
  parameter int COL_W  = 10,
  parameter int CH_W   = 1,
  parameter int T_CL   = 4,
  parameter int T_RCD  = 4,
  parameter int T_RAS  = 14,
  parameter int T_PA   = 18,
  localparam int ADDR_W = 32,
  localparam int BANK_W = $clog2(NBANK),
  localparam int ROW_W  = ADDR_W - CH_W - BANK_W - COL_W,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(T_PA + T_RAS + T_RCD + T_CL + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_closed_page,
  input  logic [WAIT_W-1:0] cfg_starve_lim,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  output logic [1:0]        mem_cmd,
  output logic [BANK_W-1:0] mem_bank,
  output logic [ROW_W-1:0]  mem_row,
  output logic [COL_W-1:0]  mem_col,
  output logic [CH_W-1:0]   mem_chan,
  output logic              mem_write,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag,
  output logic              done_write
);
  logic [DEPTH-1:0]             ent_vld, ent_write;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][TAG_W-1:0]  ent_tag;
  logic [DEPTH-1:0][WAIT_W-1:0] ent_wait;
  logic [DEPTH-1:0][BANK_W-1:0] ent_bank;
  logic [DEPTH-1:0][ROW_W-1:0]  ent_row;
  logic                         sel_any, pop, load;
  logic [IDX_W-1:0]             sel_idx;
  logic [BANK_W-1:0]            sel_bank;
  logic [ROW_W-1:0]             sel_row;

  logic [NBANK-1:0]             b_open, b_mpre, b_mact, b_mcas;
  logic [NBANK-1:0][ROW_W-1:0]  b_row;
  logic [NBANK-1:0]             pre_v, act_v, cas_v;

  dstate_e           st_q, st_n;
  dcmd_e             cmd;
  logic [CNT_W-1:0]  cl_q, cl_n, since_cas_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [TAG_W-1:0]  cur_tag_q;
  logic              cur_wr_q;
  logic [BANK_W-1:0] cur_bank;
  logic [ROW_W-1:0]  cur_row;

  dsch_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .WAIT_W(WAIT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready),
    .in_write(req_write), .in_addr(req_addr), .in_tag(req_tag),
    .pop(pop), .pop_idx(sel_idx), .ent_vld(ent_vld), .ent_write(ent_write),
    .ent_addr(ent_addr), .ent_tag(ent_tag), .ent_wait(ent_wait)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_bank[i] = ent_addr[i][COL_W +: BANK_W];
      ent_row[i]  = ent_addr[i][ADDR_W-1 -: ROW_W];
    end
  end

  dsch_pick #(.DEPTH(DEPTH), .WAIT_W(WAIT_W), .NBANK(NBANK), .ROW_W(ROW_W)) u_pick (
    .ent_vld(ent_vld), .ent_write(ent_write), .ent_bank(ent_bank), .ent_row(ent_row),
    .ent_wait(ent_wait), .bank_open(b_open), .bank_row(b_row),
    .starve_lim(cfg_starve_lim), .sel_any(sel_any), .sel_idx(sel_idx)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dsch_bank #(.ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_PA(T_PA)) u_bank (
      .clk(clk), .rst_n(rst_n), .do_pre(pre_v[b]), .do_act(act_v[b]), .do_cas(cas_v[b]),
      .act_row(cur_row), .is_open(b_open[b]), .open_row(b_row[b]),
      .may_pre(b_mpre[b]), .may_act(b_mact[b]), .may_cas(b_mcas[b])
    );
  end

  assign sel_bank = ent_bank[sel_idx];
  assign sel_row  = ent_row[sel_idx];
  assign cur_bank = cur_addr_q[COL_W +: BANK_W];
  assign cur_row  = cur_addr_q[ADDR_W-1 -: ROW_W];

  always_comb begin
    st_n = st_q;
    cl_n = cl_q;
    cmd  = CMD_NOP;
    pop  = 1'b0;
    load = 1'b0;
    case (st_q)
      ST_IDLE: if (sel_any) begin
        pop  = 1'b1;
        load = 1'b1;
        if (!b_open[sel_bank])              st_n = ST_ACT;
        else if (b_row[sel_bank] == sel_row) st_n = ST_CAS;
        else                                st_n = ST_PRE;
      end
      ST_PRE: if (b_mpre[cur_bank]) begin
        cmd  = CMD_PRE;
        st_n = ST_ACT;
      end
      ST_ACT: if (b_mact[cur_bank]) begin
        cmd  = CMD_ACT;
        st_n = ST_CAS;
      end
      ST_CAS: if (b_mcas[cur_bank]) begin
        cmd  = CMD_CAS;
        cl_n = CNT_W'(T_CL-1);
        st_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (cl_q == '0) st_n = cfg_closed_page ? ST_APRE : ST_IDLE;
        else            cl_n = cl_q - 1'b1;
      end
      ST_APRE: if (b_mpre[cur_bank]) begin
        cmd  = CMD_PRE;
        st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign pre_v = (cmd == CMD_PRE) ? (NBANK'(1) << cur_bank) : '0;
  assign act_v = (cmd == CMD_ACT) ? (NBANK'(1) << cur_bank) : '0;
  assign cas_v = (cmd == CMD_CAS) ? (NBANK'(1) << cur_bank) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      cl_q <= '0;
    end else begin
      st_q <= st_n;
      cl_q <= cl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      cur_addr_q <= ent_addr[sel_idx];
      cur_tag_q  <= ent_tag[sel_idx];
      cur_wr_q   <= ent_write[sel_idx];
    end
  end

  assign mem_cmd    = cmd;
  assign mem_bank   = cur_bank;
  assign mem_row    = cur_row;
  assign mem_col    = cur_addr_q[COL_W-1:0];
  assign mem_chan   = cur_addr_q[COL_W+BANK_W +: CH_W];
  assign mem_write  = (cmd == CMD_CAS) && cur_wr_q;
  assign done_valid = (st_q == ST_WAIT) && (cl_q == '0);
  assign done_tag   = cur_tag_q;
  assign done_write = cur_wr_q;

  // Cycles since the last column command, kept for the latency check.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_cas_q <= '0;
    else if (cmd == CMD_CAS)     since_cas_q <= CNT_W'(1);
    else if (since_cas_q != '1)  since_cas_q <= since_cas_q + 1'b1;
  end

  assert_done_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (since_cas_q == CNT_W'(T_CL)));

  assert_no_pick_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (st_q == ST_IDLE));
endmodule

// File: tb/test_dram_sched.sv
module test_dram_sched;
  localparam int T_CL = 4, T_RCD = 4, T_RAS = 14, T_PA = 18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_closed_page;
  logic [7:0]  cfg_starve_lim;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr;
  logic [7:0]  req_tag;
  logic [1:0]  mem_cmd;
  logic [2:0]  mem_bank;
  logic [17:0] mem_row;
  logic [9:0]  mem_col;
  logic [0:0]  mem_chan;
  logic        mem_write, done_valid, done_write;
  logic [7:0]  done_tag;

  dram_sched i_dram_sched (
    .clk(clk), .rst_n(rst_n), .cfg_closed_page(cfg_closed_page),
    .cfg_starve_lim(cfg_starve_lim), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_tag(req_tag),
    .mem_cmd(mem_cmd), .mem_bank(mem_bank), .mem_row(mem_row), .mem_col(mem_col),
    .mem_chan(mem_chan), .mem_write(mem_write), .done_valid(done_valid),
    .done_tag(done_tag), .done_write(done_write)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    tag; bit wr; int row; int bank; int col; int ch;
    int    npre; int nact; string rq;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0, n_bad = 0, cyc = 0;
  int   m_open[8], m_row[8], last_act[8], last_pre[8];
  int   last_cas = -1000, w_pre = 0, w_act = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string rq, string what, longint got, longint expv);
    n_chk++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, got, expv);
    end
  endtask

  task automatic expect_req(int tag, bit wr, int row, int bank, int col, int ch,
                            int npre, int nact, string rq);
    exp_t e;
    e.tag = tag; e.wr = wr; e.row = row; e.bank = bank; e.col = col; e.ch = ch;
    e.npre = npre; e.nact = nact; e.rq = rq;
    sb.push_back(e);
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic send(int tag, bit wr, int row, int bank, int col, int ch);
    req_valid = 1'b1;
    req_write = wr;
    req_tag   = tag[7:0];
    req_addr  = {row[17:0], ch[0], bank[2:0], col[9:0]};
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (sb.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // Monitor: own open-row model, timing gaps, command counts, scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      int b;
      b = int'(mem_bank);
      case (mem_cmd)
        2'd1: begin
          chk("R3", "precharge to open bank", m_open[b], 1);
          chk("R8", "act to pre gap ok", (cyc - last_act[b]) >= T_RAS, 1);
          m_open[b] = 0; last_pre[b] = cyc; w_pre++;
        end
        2'd2: begin
          chk("R3", "activate to closed bank", m_open[b], 0);
          chk("R8", "pre to act gap ok", (cyc - last_pre[b]) >= T_PA, 1);
          m_open[b] = 1; m_row[b] = int'(mem_row); last_act[b] = cyc; w_act++;
        end
        2'd3: begin
          chk("R2", "column to open row", m_open[b] == 1 && m_row[b] == int'(mem_row), 1);
          chk("R8", "act to column gap ok", (cyc - last_act[b]) >= T_RCD, 1);
          last_cas = cyc;
          if (sb.size() != 0) begin
            chk("R1", "bank field", b, sb[0].bank);
            chk("R1", "row field", int'(mem_row), sb[0].row);
            chk("R1", "column field", int'(mem_col), sb[0].col);
            chk("R1", "channel field", int'(mem_chan), sb[0].ch);
            chk("R1", "write strobe", mem_write, sb[0].wr);
          end
        end
        default: ;
      endcase
      if (done_valid) begin
        if (sb.size() == 0) chk("R4", "unexpected completion", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(e.rq, "completion tag order", int'(done_tag), e.tag);
          chk("R4", "completion write flag", done_write, e.wr);
          chk("R4", "cas to done latency", cyc - last_cas, T_CL);
          chk("R3", "precharges for request", w_pre, e.npre);
          chk("R3", "activates for request", w_act, e.nact);
        end
        w_pre = 0; w_act = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_open[i] = 0; m_row[i] = 0; last_act[i] = -1000; last_pre[i] = -1000;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_tag = '0;
    cfg_closed_page = 1'b0; cfg_starve_lim = 8'd255;
    repeat (3) @(negedge clk);
    chk("R9", "ready in reset", req_ready, 1);
    chk("R4", "no completion in reset", done_valid, 0);
    chk("R2", "no command in reset", mem_cmd, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Closed bank, then hit, then miss on an open bank (R2, R3)
    expect_req(1, 0, 5, 0, 7, 0, 0, 1, "R3");
    send(1, 0, 5, 0, 7, 0);
    wait_idle();
    expect_req(2, 0, 5, 0, 3, 1, 0, 0, "R2");
    send(2, 0, 5, 0, 3, 1);
    wait_idle();
    expect_req(3, 1, 9, 0, 12, 0, 1, 1, "R3");
    send(3, 1, 9, 0, 12, 0);
    wait_idle();

    // Read hit beats read miss beats write hit (R5)
    expect_req(4, 0, 2, 1, 1, 0, 0, 1, "R5");
    expect_req(7, 0, 9, 0, 5, 0, 0, 0, "R5");
    expect_req(6, 0, 1, 2, 2, 1, 0, 1, "R5");
    expect_req(5, 1, 9, 0, 4, 0, 0, 0, "R5");
    send(4, 0, 2, 1, 1, 0);
    send(5, 1, 9, 0, 4, 0);
    send(6, 0, 1, 2, 2, 1);
    send(7, 0, 9, 0, 5, 0);
    wait_idle();

    // Among reads, a younger hit overtakes an older miss (R5)
    expect_req(8, 1, 1, 3, 0, 0, 0, 1, "R5");
    expect_req(10, 0, 9, 0, 8, 0, 0, 0, "R5");
    expect_req(9, 0, 4, 0, 6, 0, 1, 1, "R5");
    send(8, 1, 1, 3, 0, 0);
    send(9, 0, 4, 0, 6, 0);
    send(10, 0, 9, 0, 8, 0);
    wait_idle();

    // Starved write promoted above a read (R6)
    cfg_starve_lim = 8'd3;
    expect_req(11, 0, 1, 4, 0, 0, 0, 1, "R6");
    expect_req(12, 1, 1, 5, 0, 0, 0, 1, "R6");
    expect_req(13, 0, 1, 6, 0, 1, 0, 1, "R6");
    send(11, 0, 1, 4, 0, 0);
    send(12, 1, 1, 5, 0, 0);
    send(13, 0, 1, 6, 0, 1);
    wait_idle();
    cfg_starve_lim = 8'd255;

    // Full buffer holds off a fifth request without loss (R9)
    expect_req(20, 0, 1, 7, 0, 0, 0, 1, "R9");
    for (int t = 21; t <= 25; t++) expect_req(t, 0, 1, 7, t, 0, 0, 0, "R9");
    send(20, 0, 1, 7, 0, 0);
    for (int t = 21; t <= 24; t++) send(t, 0, 1, 7, t, 0);
    chk("R9", "ready low when full", req_ready, 0);
    send(25, 0, 1, 7, 25, 0);
    wait_idle();

    // Closed-page: hit, then auto precharge forces a fresh activate (R7)
    cfg_closed_page = 1'b1;
    @(negedge clk);
    expect_req(30, 0, 2, 1, 9, 0, 0, 0, "R7");
    send(30, 0, 2, 1, 9, 0);
    wait_idle();
    chk("R7", "row closed after access", m_open[1], 0);
    expect_req(31, 1, 2, 1, 10, 0, 1, 1, "R7");
    send(31, 1, 2, 1, 10, 0);
    wait_idle();
    chk("R7", "row closed after second access", m_open[1], 0);
    chk("R4", "all completions seen", sb.size(), 0);

    summary();
    $finish;
  end
endmodule